// File: doc/BRIEF.md
# Multi-PHY Transmit Cell-Slot Poller

This block is the master side of a multi-PHY cell transmit port. It finds out which attached PHY devices have room for another cell and grants the next cell slot to one of them. A single mode input selects one of two polling styles, and the mode may change while the block runs. In shared-line mode the block steps a 5-bit address through the active PHYs and reads one common cell-available line one clock later. In direct mode it reads four cell-available lines at once and places a 2-bit selection on the low address bits.

An upstream scheduler supplies one pending flag per PHY. When the block is idle and a PHY both reports room and has a pending cell, the block grants that PHY in round-robin order. It then holds the transmit enable for one whole cell. The cell is either the standard 53 bytes or a user-programmed byte count. The cell data path, header checksum generation and the receive side are handled elsewhere.

Top module: `utx_poller`

## Requirements
- R1: While reset is asserted and on release, `phy_addr` is 31 (the null address), `tx_en` is 0, and no PHY is recorded as having room.
- R2: In shared-line mode (`cfg_direct`=0), with no grant taking place, `phy_addr` repeats the sequence 0, 1, …, `cfg_phy_count`-1, 31, advancing by one step per clock. With `cfg_phy_count`=0 it stays at 31.
- R3: In shared-line mode, `clav[0]` sampled in the clock after address A was driven (A not 31, not a grant cycle) becomes the recorded room state of PHY A. The other `clav` bits are ignored.
- R4: In direct mode (`cfg_direct`=1), `clav[i]` for i=0..3 is recorded each clock as the room state of PHY i. PHYs 4 and above count as having no room. `phy_addr[4:2]` is 0, and `phy_addr[1:0]` holds the most recently granted PHY (0 after reset).
- R5: A grant goes only to a PHY that has recorded room, has its `cell_pending` bit set, and is active. In shared-line mode a PHY is active when its index is below `cfg_phy_count`; in direct mode, when its index is below 4. The search starts at the PHY after the one granted last (PHY 0 first after reset) and wraps modulo 31.
- R6: While `tx_en` is high no new grant is made. After `tx_en` falls it stays low for at least one clock.
- R7: `tx_en` stays high for exactly L consecutive clocks. L is 53 when `cfg_user_len`=0. L is `cfg_cell_bytes` when `cfg_user_len`=1, and a value of 0 there counts as 1.
- R8: The clock in which `tx_en` rises shows the granted PHY on `phy_addr`: all 5 bits in shared-line mode, or the low 2 bits in direct mode. Polling resumes where it paused on the next clock.
- R9: Granting a PHY clears its recorded room. It must report room again before it can be granted again.
- R10: Address 31 is never granted. At every rising edge of `tx_en`, `phy_addr` is not 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_direct | input | 1 | Polling mode: 0 shared line with 5-bit address, 1 four direct lines |
| cfg_user_len | input | 1 | 0 standard 53-byte cells, 1 user-defined cell length |
| cfg_cell_bytes | input | 8 | User-defined cell length in bytes |
| cfg_phy_count | input | 5 | Number of active PHYs scanned in shared-line mode |
| cell_pending | input | 31 | Per-PHY flag: a cell is waiting for that PHY |
| clav | input | 4 | Cell-available lines; only bit 0 used in shared-line mode |
| phy_addr | output | 5 | Poll/selection address |
| tx_en | output | 1 | Transmit enable, high for one cell time |

## Verification
If a PHY's room state is recorded wrongly, the wrong PHY rises with `tx_en`, or a PHY that should be granted is not. This is visible within one cell time of the poll that set the state. A poll pointer that is off by one shows on `phy_addr` in the very next clock, because the address sequence is fully predictable. A faulty cell counter changes the length of the `tx_en` pulse, and the rising edge of that pulse exposes the round-robin order. The reference model follows the address, the enable and each PHY's room state clock by clock, so any difference appears in the clock where it starts.

// File: rtl/utxp_pkg.sv
package utxp_pkg;
  localparam int STD_CELL_BYTES = 53;

  typedef enum logic {
    POLL_SHARED = 1'b0,
    POLL_DIRECT = 1'b1
  } poll_mode_e;
endpackage

// File: rtl/utxp_scan.sv
module utxp_scan #(
  parameter int N_PHY = 31,
  parameter int AW    = 5,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  utxp_pkg::poll_mode_e mode,
  input  logic [AW-1:0]    act_count,
  input  logic             grant,
  input  logic [AW-1:0]    winner,
  input  logic [SEL_W-1:0] cur_low,
  output logic [AW-1:0]    phy_addr,
  output logic             smp_valid,
  output logic [AW-1:0]    smp_addr
);
  localparam logic [AW-1:0] NULL_ADDR = {AW{1'b1}};

  logic [AW-1:0]    ptr_q, ptr_d;
  logic [AW-1:0]    addr_d, smp_addr_d, poll_addr;
  logic             smp_valid_d;
  logic [SEL_W-1:0] sel_low;

  always_comb begin
    poll_addr   = (ptr_q >= act_count) ? NULL_ADDR : ptr_q;
    sel_low     = grant ? winner[SEL_W-1:0] : cur_low;
    ptr_d       = ptr_q;
    smp_valid_d = 1'b0;
    smp_addr_d  = poll_addr;
    if (mode == utxp_pkg::POLL_DIRECT) begin
      ptr_d  = '0;
      addr_d = AW'(sel_low);
    end else begin
      addr_d      = grant ? winner : poll_addr;
      smp_valid_d = !grant && (poll_addr != NULL_ADDR);
      if (!grant) ptr_d = (ptr_q >= act_count) ? '0 : ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      phy_addr  <= NULL_ADDR;
      smp_valid <= 1'b0;
      smp_addr  <= NULL_ADDR;
    end else begin
      ptr_q     <= ptr_d;
      phy_addr  <= addr_d;
      smp_valid <= smp_valid_d;
      smp_addr  <= smp_addr_d;
    end
  end
endmodule

// File: rtl/utxp_ready.sv
module utxp_ready #(
  parameter int N_PHY    = 31,
  parameter int N_DIRECT = 4,
  parameter int AW       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  utxp_pkg::poll_mode_e mode,
  input  logic [N_DIRECT-1:0] clav,
  input  logic                smp_valid,
  input  logic [AW-1:0]       smp_addr,
  input  logic                grant,
  input  logic [AW-1:0]       winner,
  output logic [N_PHY-1:0]    ready_q
);
  logic [N_PHY-1:0] ready_d;

  always_comb begin
    ready_d = ready_q;
    if (mode == utxp_pkg::POLL_DIRECT) begin
      ready_d                = '0;
      ready_d[N_DIRECT-1:0]  = clav;
    end else if (smp_valid && (smp_addr < AW'(N_PHY))) begin
      ready_d[smp_addr] = clav[0];
    end
    if (grant) ready_d[winner] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= '0;
    else        ready_q <= ready_d;
  end
endmodule

// File: rtl/utxp_arb.sv
module utxp_arb #(
  parameter int N_PHY = 31,
  parameter int AW    = 5
) (
  input  logic             enable,
  input  logic [N_PHY-1:0] elig,
  input  logic [AW-1:0]    last,
  output logic             grant,
  output logic [AW-1:0]    winner
);
  always_comb begin
    grant  = 1'b0;
    winner = '0;
    for (int k = 1; k <= N_PHY; k++) begin
      int idx;
      idx = int'(last) + k;
      if (idx >= N_PHY) idx = idx - N_PHY;
      if (enable && !grant && elig[idx]) begin
        grant  = 1'b1;
        winner = AW'(idx);
      end
    end
  end
endmodule

// File: rtl/utxp_cell.sv
module utxp_cell #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic [LEN_W-1:0] cell_len,
  output logic             busy_q,
  output logic [LEN_W-1:0] cnt_q
);
  logic             busy_d;
  logic [LEN_W-1:0] cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (grant) begin
      busy_d = 1'b1;
      cnt_d  = LEN_W'(1);
    end else if (busy_q) begin
      if (cnt_q >= cell_len) busy_d = 1'b0;
      else                   cnt_d  = cnt_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/utx_poller.sv
module utx_poller #(
  parameter int N_PHY    = 31,
  parameter int N_DIRECT = 4,
  parameter int LEN_W    = 8,
  localparam int AW      = $clog2(N_PHY + 1),
  localparam int SEL_W   = $clog2(N_DIRECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_direct,
  input  logic                cfg_user_len,
  input  logic [LEN_W-1:0]    cfg_cell_bytes,
  input  logic [AW-1:0]       cfg_phy_count,
  input  logic [N_PHY-1:0]    cell_pending,
  input  logic [N_DIRECT-1:0] clav,
  output logic [AW-1:0]       phy_addr,
  output logic                tx_en
);
  import utxp_pkg::*;

  poll_mode_e       mode;
  logic [AW-1:0]    eff_count;
  logic [LEN_W-1:0] cell_len, cnt_q;
  logic [N_PHY-1:0] ready_q, elig;
  logic             grant, smp_valid;
  logic [AW-1:0]    winner, smp_addr, rr_last_q, cur_sel;

  assign mode      = poll_mode_e'(cfg_direct);
  assign eff_count = (cfg_phy_count > AW'(N_PHY)) ? AW'(N_PHY) : cfg_phy_count;
  assign cell_len  = !cfg_user_len ? LEN_W'(STD_CELL_BYTES) :
                     (cfg_cell_bytes == '0) ? LEN_W'(1) : cfg_cell_bytes;

  for (genvar i = 0; i < N_PHY; i++) begin : g_elig
    logic active;
    assign active  = (mode == POLL_DIRECT) ? (i < N_DIRECT) : (AW'(i) < eff_count);
    assign elig[i] = ready_q[i] & cell_pending[i] & active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_last_q <= AW'(N_PHY - 1);
      cur_sel   <= '0;
    end else if (grant) begin
      rr_last_q <= winner;
      cur_sel   <= winner;
    end
  end

  utxp_arb #(.N_PHY(N_PHY), .AW(AW)) u_arb (
    .enable(!tx_en), .elig(elig), .last(rr_last_q),
    .grant(grant), .winner(winner)
  );

  utxp_scan #(.N_PHY(N_PHY), .AW(AW), .SEL_W(SEL_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .mode(mode), .act_count(eff_count),
    .grant(grant), .winner(winner), .cur_low(cur_sel[SEL_W-1:0]),
    .phy_addr(phy_addr), .smp_valid(smp_valid), .smp_addr(smp_addr)
  );

  utxp_ready #(.N_PHY(N_PHY), .N_DIRECT(N_DIRECT), .AW(AW)) u_ready (
    .clk(clk), .rst_n(rst_n), .mode(mode), .clav(clav),
    .smp_valid(smp_valid), .smp_addr(smp_addr),
    .grant(grant), .winner(winner), .ready_q(ready_q)
  );

  utxp_cell #(.LEN_W(LEN_W)) u_cell (
    .clk(clk), .rst_n(rst_n), .grant(grant), .cell_len(cell_len),
    .busy_q(tx_en), .cnt_q(cnt_q)
  );
endmodule

// File: rtl/utxp_checker.sv
module utxp_checker #(
  parameter int N_PHY = 31,
  parameter int AW    = 5,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_direct,
  input logic             tx_en,
  input logic [AW-1:0]    phy_addr,
  input logic             grant,
  input logic [AW-1:0]    winner,
  input logic [N_PHY-1:0] ready_q,
  input logic [N_PHY-1:0] cell_pending,
  input logic [LEN_W-1:0] cnt_q,
  input logic [LEN_W-1:0] cell_len,
  input logic [AW-1:0]    cur_sel
);
  logic up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  assert_direct_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(cfg_direct)) |-> (phy_addr[AW-1:2] == '0));

  assert_grant_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (ready_q[winner] && cell_pending[winner] && !tx_en));

  assert_cell_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && (cnt_q < cell_len)) |=> (tx_en && $stable(cur_sel)));

  assert_cell_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $fell(tx_en)) |-> ($past(cnt_q) >= $past(cell_len)));

  assert_room_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !ready_q[$past(winner)]);

  assert_no_null_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $rose(tx_en)) |-> (phy_addr != {AW{1'b1}}));
endmodule

bind utx_poller utxp_checker #(.N_PHY(N_PHY), .AW(AW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_direct(cfg_direct), .tx_en(tx_en),
  .phy_addr(phy_addr), .grant(grant), .winner(winner), .ready_q(ready_q),
  .cell_pending(cell_pending), .cnt_q(cnt_q), .cell_len(cell_len),
  .cur_sel(cur_sel)
);

// File: tb/sim_utx_poller.sv
module sim_utx_poller;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_direct = 1'b0, cfg_user_len = 1'b0;
  logic [7:0]  cfg_cell_bytes = 8'd0;
  logic [4:0]  cfg_phy_count = 5'd0;
  logic [30:0] cell_pending = '0;
  logic [3:0]  clav = '0;
  logic [4:0]  phy_addr;
  logic        tx_en;

  int checks = 0, failures = 0;
  int pend_mode = 0;
  int run_len = 0;
  bit prev_tx = 0;
  bit done = 0;

  always #4 clk = ~clk;

  utx_poller u0 (
    .clk(clk), .rst_n(rst_n), .cfg_direct(cfg_direct), .cfg_user_len(cfg_user_len),
    .cfg_cell_bytes(cfg_cell_bytes), .cfg_phy_count(cfg_phy_count),
    .cell_pending(cell_pending), .clav(clav), .phy_addr(phy_addr), .tx_en(tx_en)
  );

  // Behavioural reference model
  int m_ptr, m_smpa, m_phy, m_cnt, m_last, m_cur;
  bit m_smpv, m_busy;
  bit m_ready[31];

  function automatic int exp_len();
    if (!cfg_user_len) return 53;          // R7
    return (cfg_cell_bytes == 0) ? 1 : int'(cfg_cell_bytes);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin                      // R1
      m_ptr = 0; m_smpa = 31; m_smpv = 0; m_phy = 31; m_busy = 0;
      m_cnt = 0; m_last = 30; m_cur = 0;
      foreach (m_ready[i]) m_ready[i] = 0;
    end else begin
      int w, paddr, cnt;
      w = -1;
      cnt = int'(cfg_phy_count);
      if (!m_busy)                         // R5 R6
        for (int k = 1; k <= 31; k++) begin
          int idx;
          idx = (m_last + k) % 31;
          if (w < 0 && m_ready[idx] && cell_pending[idx] &&
              (cfg_direct ? (idx < 4) : (idx < cnt))) w = idx;
        end
      paddr = (m_ptr >= cnt) ? 31 : m_ptr;
      if (cfg_direct) begin                // R4
        for (int i = 0; i < 31; i++) m_ready[i] = (i < 4) ? clav[i] : 1'b0;
      end else if (m_smpv) begin           // R3
        m_ready[m_smpa] = clav[0];
      end
      if (w >= 0) begin                    // R9
        m_ready[w] = 0; m_last = w; m_cur = w; m_busy = 1; m_cnt = 1;
      end else if (m_busy) begin           // R7
        if (m_cnt >= exp_len()) m_busy = 0;
        else m_cnt = m_cnt + 1;
      end
      if (cfg_direct) begin
        m_phy = m_cur % 4; m_smpv = 0; m_ptr = 0;
      end else begin                       // R2 R8
        m_phy = (w >= 0) ? w : paddr;
        m_smpv = (w < 0) && (paddr != 31);
        m_smpa = paddr;
        if (w < 0) m_ptr = (m_ptr >= cnt) ? 0 : m_ptr + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_inputs();
    clav = 4'($urandom % 16) | ((($urandom % 4) != 0) ? 4'b0001 : 4'b0000);
    case (pend_mode)
      0: cell_pending = '0;
      1: cell_pending = '1;
      2: cell_pending = 31'($urandom);
      default: cell_pending = 31'h0000_0084;   // PHYs 2 and 7
    endcase
  endtask

  // Per-clock comparison, away from the active edge
  task automatic cycles(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check(phy_addr == 5'(m_phy), "R2/R3/R4/R8 phy_addr", int'(phy_addr), m_phy);
      check(tx_en == m_busy, "R5/R6/R9 tx_en", int'(tx_en), int'(m_busy));
      if (tx_en && !prev_tx)
        check(phy_addr != 5'd31, "R10 null never granted", int'(phy_addr), 0);
      if (!tx_en && prev_tx)
        check(run_len == exp_len(), "R7 cell length", run_len, exp_len());
      run_len = tx_en ? run_len + 1 : 0;
      prev_tx = tx_en;
      drive_inputs();
    end
  endtask

  task automatic phase(input bit dir, input int cnt, input bit ul, input int ub,
                       input int pm, input int n, input bit drain);
    if (drain) begin pend_mode = 0; cycles(80); end
    cfg_direct = dir; cfg_phy_count = 5'(cnt);
    cfg_user_len = ul; cfg_cell_bytes = 8'(ub);
    pend_mode = pm;
    cycles(n);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(phy_addr == 5'd31, "R1 reset address", int'(phy_addr), 31);
    check(tx_en == 1'b0, "R1 reset enable", int'(tx_en), 0);
    rst_n = 1'b1;
    check(phy_addr == 5'd31, "R1 release address", int'(phy_addr), 31);
    phase(0, 5, 0, 0, 1, 1500, 0);   // R2 R3 R7 standard cells
    phase(0, 5, 1, 6, 2, 1500, 1);   // R5 user length
    phase(0, 0, 1, 4, 1, 300, 1);    // R2 only null address
    phase(0, 31, 1, 0, 2, 2000, 1);  // R7 zero length counts as one
    phase(1, 5, 1, 9, 2, 1500, 1);   // R4 direct mode
    phase(1, 5, 1, 9, 3, 800, 0);    // R5 PHY 7 inactive in direct
    phase(0, 3, 1, 9, 2, 1500, 0);   // run-time mode switch
    phase(1, 3, 1, 9, 1, 800, 0);    // back to direct mid-stream
    phase(0, 12, 1, 3, 2, 1500, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule